// File: doc/BRIEF.md
# Matrix Keypad Column Scanner

This block scans a switch matrix built from rows and columns. It pulls one column line low at a time and reads the row lines, which are active-low, already synchronised and pulled up. Each column stays driven for a fixed settling window of `SENSE_CYCLES` clocks. The rows are sampled once, on the last cycle of that window. A slow, high-resistance contact therefore has the whole window to discharge the input capacitance before it is read.

Each column has its own registered decoder. The decoder turns the sampled row pattern into an 8-bit key code, an active flag and an error flag. It holds that result until the same column comes round again, so the results of every column are present together. A merge stage ORs the column codes into one key code. It raises `key_error` when a column saw several rows or when several columns are active. It raises `key_valid` only when exactly one column is active and there is no error.

A one-cycle `scan_done` strobe marks the point where a full sweep has completed. That is where a later debouncer is meant to sample the merged outputs.

Top module: `kpd_matrix_scanner`

## Requirements
- R1: Exactly one bit of `col_n` is low in every cycle. The driven column steps through indices 0, 1, …, NUM_COLS-1 and then back to 0, repeating.
- R2: Each column stays driven for exactly `SENSE_CYCLES` consecutive cycles. The next column is driven on the very next cycle, with no gap between columns.
- R3: A column's rows are sampled only on the last cycle of its drive window. A row that goes low and returns high earlier in that window leaves no trace in the outputs.
- R4: A single pressed key produces its code on `key_code`, with `key_valid`=1 and `key_error`=0. A key is single when exactly one row of one column is low (`row_n[r]`=0 while `col_n[c]`=0).
  - `KEY_TABLE` is a string of NUM_COLS×NUM_ROWS 8-bit codes, read from the left.
  - Column 0 comes first, and within each column the rows follow in order 0 to NUM_ROWS-1.
  - The default table is "1470258F369EABCD".
- R5: When no key is pressed anywhere, `key_code`=0, `key_valid`=0 and `key_error`=0 after a full sweep.
- R6: Two or more rows low in one column raise `key_error` and force `key_valid` to 0.
- R7: A column's decoded result holds until that column is sampled again. Releasing a key after its column has been sampled leaves `key_valid` and `key_code` unchanged until the next sample of that column.
- R8: Single keys active in more than one column raise `key_error` and force `key_valid` to 0.
- R9: During reset every column holds code 0, inactive and error. The outputs are then `key_error`=1, `key_valid`=0 and `key_code`=0, with column 0 driven (`col_n`=all ones except bit 0) and `scan_done`=0.
- R10: `scan_done` is high for exactly one cycle, once every NUM_COLS×SENSE_CYCLES cycles. It is high in the first cycle after the last column has been sampled, which is also the first cycle in which column 0 is driven again.
- R11: `key_code` is the bitwise OR of the held codes of all columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_n | input | NUM_ROWS | Row sense lines, 0 = key pressed in the driven column |
| col_n | output | NUM_COLS | Column drive lines, 0 = driven, straight from flip-flops |
| key_code | output | CODE_W | Merged key code |
| key_valid | output | 1 | Exactly one key found and no error |
| key_error | output | 1 | Multiple rows in one column, or multiple active columns |
| scan_done | output | 1 | One-cycle strobe after each full sweep |

## Verification
Two things happen on the same edge: the end-of-window sample is captured, and the drive moves on to the next column. The tests provoke this by releasing a key just before the last cycle of its column window. The outputs must then show no key, which judges that the capture uses the settled value. The same edge also completes each sweep, so `scan_done` and the first cycle of column 0 must appear together. The bench checks that coincidence cycle by cycle over two full sweeps.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

   // Classification of one column's sampled row pattern
   typedef enum logic [1:0] {
      PAT_IDLE  = 2'd0,   // no row low
      PAT_ONE   = 2'd1,   // exactly one row low
      PAT_MULTI = 2'd2    // two or more rows low
   } row_pat_e;

endpackage

// File: rtl/kpd_col_sequencer.sv
// Column drive sequencer: dwell counter, column index, registered
// active-low drive lines and the end-of-sweep strobe.
module kpd_col_sequencer #(
   parameter int NUM_COLS     = 4,
   parameter int SENSE_CYCLES = 833,
   localparam int IDX_W       = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
   localparam int CNT_W       = (SENSE_CYCLES > 1) ? $clog2(SENSE_CYCLES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [NUM_COLS-1:0] col_n,
   output logic [IDX_W-1:0]    col_idx,
   output logic                sample,
   output logic                scan_done
);

   logic [CNT_W-1:0]    dwell_q;
   logic [IDX_W-1:0]    idx_nxt;
   logic [NUM_COLS-1:0] drive_nxt;
   logic                last_col;

   assign sample   = (dwell_q == CNT_W'(SENSE_CYCLES - 1));
   assign last_col = (col_idx == IDX_W'(NUM_COLS - 1));

   always_comb begin
      idx_nxt = last_col ? '0 : col_idx + 1'b1;
      for (int c = 0; c < NUM_COLS; c++) begin
         drive_nxt[c] = (IDX_W'(c) != idx_nxt);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dwell_q   <= '0;
         col_idx   <= '0;
         col_n     <= {{(NUM_COLS-1){1'b1}}, 1'b0};
         scan_done <= 1'b0;
      end else begin
         scan_done <= sample && last_col;
         if (sample) begin
            dwell_q <= '0;
            col_idx <= idx_nxt;
            col_n   <= drive_nxt;
         end else begin
            dwell_q <= dwell_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/kpd_col_slice.sv
// One column's registered decoder. Captures the row pattern when told to
// and holds code / active / error until the next capture.
module kpd_col_slice
   import kpd_pkg::*;
#(
   parameter int NUM_ROWS = 4,
   parameter int CODE_W   = 8,
   parameter logic [NUM_ROWS*CODE_W-1:0] CODES = '0,
   localparam int ZC_W = $clog2(NUM_ROWS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [NUM_ROWS-1:0] row_n,
   output logic [CODE_W-1:0] code_q,
   output logic              active_q,
   output logic              error_q
);

   logic [ZC_W-1:0]   zero_cnt;
   logic [CODE_W-1:0] hit_code;
   row_pat_e          pat;

   always_comb begin
      zero_cnt = '0;
      hit_code = '0;
      for (int r = 0; r < NUM_ROWS; r++) begin
         if (!row_n[r]) begin
            zero_cnt = zero_cnt + 1'b1;
            hit_code = hit_code | CODES[(NUM_ROWS-1-r)*CODE_W +: CODE_W];
         end
      end
      if (zero_cnt == '0)
         pat = PAT_IDLE;
      else if (zero_cnt == ZC_W'(1))
         pat = PAT_ONE;
      else
         pat = PAT_MULTI;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q   <= '0;
         active_q <= 1'b0;
         error_q  <= 1'b1;
      end else if (capture) begin
         unique case (pat)
            PAT_IDLE: begin
               code_q   <= '0;
               active_q <= 1'b0;
               error_q  <= 1'b0;
            end
            PAT_ONE: begin
               code_q   <= hit_code;
               active_q <= 1'b1;
               error_q  <= 1'b0;
            end
            default: begin
               code_q   <= '0;
               active_q <= 1'b1;
               error_q  <= 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/kpd_merge.sv
// Combines the held per-column results into the block outputs.
module kpd_merge #(
   parameter int NUM_COLS = 4,
   parameter int CODE_W   = 8,
   localparam int AC_W    = $clog2(NUM_COLS + 1)
) (
   input  logic [NUM_COLS*CODE_W-1:0] col_codes,
   input  logic [NUM_COLS-1:0]        col_active,
   input  logic [NUM_COLS-1:0]        col_error,
   output logic [CODE_W-1:0]          key_code,
   output logic                       key_valid,
   output logic                       key_error
);

   logic [AC_W-1:0] act_cnt;
   logic            any_err;

   always_comb begin
      key_code = '0;
      act_cnt  = '0;
      for (int c = 0; c < NUM_COLS; c++) begin
         key_code = key_code | col_codes[c*CODE_W +: CODE_W];
         act_cnt  = act_cnt + AC_W'(col_active[c]);
      end
      any_err   = |col_error;
      key_error = any_err || (act_cnt > AC_W'(1));
      key_valid = !key_error && (act_cnt == AC_W'(1));
   end

endmodule

// File: rtl/kpd_matrix_scanner.sv
// Top level: sequencer, one decoder slice per column, merge.
module kpd_matrix_scanner #(
   parameter int NUM_COLS     = 4,
   parameter int NUM_ROWS     = 4,
   parameter int CODE_W       = 8,
   parameter int SENSE_CYCLES = 833,
   parameter logic [NUM_COLS*NUM_ROWS*CODE_W-1:0] KEY_TABLE = "1470258F369EABCD",
   localparam int IDX_W       = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
   localparam int COL_BITS    = NUM_ROWS * CODE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_ROWS-1:0] row_n,
   output logic [NUM_COLS-1:0] col_n,
   output logic [CODE_W-1:0]   key_code,
   output logic                key_valid,
   output logic                key_error,
   output logic                scan_done
);

   // Elaboration-time parameter checks
   if (NUM_COLS < 2) begin : g_bad_cols
      $error("kpd_matrix_scanner: NUM_COLS must be at least 2");
   end
   if (NUM_ROWS < 2) begin : g_bad_rows
      $error("kpd_matrix_scanner: NUM_ROWS must be at least 2");
   end
   if (SENSE_CYCLES < 2) begin : g_bad_sense
      $error("kpd_matrix_scanner: SENSE_CYCLES must be at least 2");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("kpd_matrix_scanner: CODE_W must be at least 1");
   end

   logic [IDX_W-1:0]           col_idx;
   logic                       sample;
   logic [NUM_COLS*CODE_W-1:0] col_codes;
   logic [NUM_COLS-1:0]        col_active;
   logic [NUM_COLS-1:0]        col_error;

   kpd_col_sequencer #(
      .NUM_COLS     (NUM_COLS),
      .SENSE_CYCLES (SENSE_CYCLES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .col_n     (col_n),
      .col_idx   (col_idx),
      .sample    (sample),
      .scan_done (scan_done)
   );

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      localparam logic [COL_BITS-1:0] COL_CODES =
         KEY_TABLE[(NUM_COLS-1-c)*COL_BITS +: COL_BITS];
      logic capture;
      assign capture = sample && (col_idx == IDX_W'(c));

      kpd_col_slice #(
         .NUM_ROWS (NUM_ROWS),
         .CODE_W   (CODE_W),
         .CODES    (COL_CODES)
      ) u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .capture  (capture),
         .row_n    (row_n),
         .code_q   (col_codes[c*CODE_W +: CODE_W]),
         .active_q (col_active[c]),
         .error_q  (col_error[c])
      );
   end

   kpd_merge #(
      .NUM_COLS (NUM_COLS),
      .CODE_W   (CODE_W)
   ) u_merge (
      .col_codes  (col_codes),
      .col_active (col_active),
      .col_error  (col_error),
      .key_code   (key_code),
      .key_valid  (key_valid),
      .key_error  (key_error)
   );

endmodule

// File: rtl/kpd_scanner_chk.sv
// Property checker for kpd_matrix_scanner, attached by bind below.
module kpd_scanner_chk #(
   parameter int NUM_COLS     = 4,
   parameter int SENSE_CYCLES = 833,
   localparam int RUN_W       = $clog2(SENSE_CYCLES + 2)
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_COLS-1:0] col_n,
   input logic                key_valid,
   input logic                key_error,
   input logic                scan_done
);

   logic [NUM_COLS-1:0] prev_col;
   logic [RUN_W-1:0]    run_cnt;

   // Counts how many consecutive samples the current drive pattern has shown
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_col <= {{(NUM_COLS-1){1'b1}}, 1'b0};
         run_cnt  <= '0;
      end else begin
         prev_col <= col_n;
         if (col_n == prev_col) begin
            if (run_cnt != {RUN_W{1'b1}})
               run_cnt <= run_cnt + 1'b1;
         end else begin
            run_cnt <= RUN_W'(1);
         end
      end
   end

   a_r1_one_col_low : assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~col_n) == 1);

   a_r2_dwell : assert property (@(posedge clk) disable iff (!rst_n)
      (col_n != prev_col) |-> (run_cnt == RUN_W'(SENSE_CYCLES)));

   a_r10_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |=> !scan_done);

   a_r10_done_at_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> (col_n[0] == 1'b0));

   a_r8_flags_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      !(key_valid && key_error));

endmodule

bind kpd_matrix_scanner kpd_scanner_chk #(
   .NUM_COLS     (NUM_COLS),
   .SENSE_CYCLES (SENSE_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .col_n     (col_n),
   .key_valid (key_valid),
   .key_error (key_error),
   .scan_done (scan_done)
);

// File: tb/kpd_matrix_scanner_tb.sv
`timescale 1ns/1ps
module kpd_matrix_scanner_tb;

   localparam int NC = 4;
   localparam int NR = 4;
   localparam int SC = 8;
   localparam logic [127:0] TBL = "1470258F369EABCD";

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NC*NR-1:0] press;
   logic [NR-1:0] row_n;
   logic [NC-1:0] col_n;
   logic [7:0]    key_code;
   logic          key_valid, key_error, scan_done;
   int            n_chk = 0;
   int            n_fail = 0;
   bit            finished = 0;

   always #2 clk = ~clk;

   // Switch matrix model: a pressed key shorts its row to its column
   always_comb begin
      for (int r = 0; r < NR; r++) begin
         row_n[r] = 1'b1;
         for (int c = 0; c < NC; c++)
            if (press[c*NR+r] && !col_n[c]) row_n[r] = 1'b0;
      end
   end

   kpd_matrix_scanner #(
      .NUM_COLS(NC), .NUM_ROWS(NR), .CODE_W(8), .SENSE_CYCLES(SC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
      .key_code(key_code), .key_valid(key_valid), .key_error(key_error),
      .scan_done(scan_done)
   );

   function automatic logic [7:0] code_of(int c, int r);
      return TBL[(15 - (c*NR + r))*8 +: 8];
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_done();
      @(negedge clk);
      while (!scan_done) @(negedge clk);
   endtask

   task automatic expect_out(input string req, input logic [7:0] code,
                             input bit v, input bit e);
      chk(key_code == code, {req, " key_code"}, 32'(key_code), 32'(code));
      chk(key_valid == v, {req, " key_valid"}, 32'(key_valid), 32'(v));
      chk(key_error == e, {req, " key_error"}, 32'(key_error), 32'(e));
   endtask

   // Apply a key set for one full sweep, then compare
   task automatic sweep_with(input logic [NC*NR-1:0] keys);
      wait_done();
      press = keys;
      wait_done();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      press = '0;
      repeat (3) @(negedge clk);
      expect_out("R9 reset", 8'h00, 1'b0, 1'b1);
      chk(col_n == 4'b1110, "R9 reset col_n", 32'(col_n), 32'hE);
      chk(scan_done == 1'b0, "R9 reset scan_done", 32'(scan_done), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_scan_timing();
      bit ok_one = 1, ok_seq = 1, ok_done = 1;
      logic [NC-1:0] exp_col;
      wait_done();
      for (int i = 0; i < 2*NC*SC; i++) begin
         exp_col = ~(NC'(1) << ((i / SC) % NC));
         if ($countones(~col_n) != 1) ok_one = 0;
         if (col_n != exp_col) ok_seq = 0;
         if (scan_done != ((i % (NC*SC)) == 0)) ok_done = 0;
         @(negedge clk);
      end
      chk(ok_one, "R1 one column low", 0, 1);
      chk(ok_seq, "R2 dwell and order", 0, 1);
      chk(ok_done, "R10 scan_done timing", 0, 1);
   endtask

   task automatic t_none();
      sweep_with('0);
      expect_out("R5 no key", 8'h00, 1'b0, 1'b0);
   endtask

   task automatic t_single();
      int cs[3] = '{0, 2, 3};
      int rs[3] = '{0, 3, 1};
      for (int k = 0; k < 3; k++) begin
         logic [NC*NR-1:0] kv = '0;
         kv[cs[k]*NR + rs[k]] = 1'b1;
         sweep_with(kv);
         expect_out("R4 single key", code_of(cs[k], rs[k]), 1'b1, 1'b0);
      end
      sweep_with('0);
   endtask

   task automatic t_multi_row();
      logic [NC*NR-1:0] kv = '0;
      kv[1*NR + 0] = 1'b1;
      kv[1*NR + 2] = 1'b1;
      sweep_with(kv);
      chk(key_error == 1'b1, "R6 two rows error", 32'(key_error), 1);
      chk(key_valid == 1'b0, "R6 two rows valid", 32'(key_valid), 0);
      sweep_with('0);
      expect_out("R6 recovery", 8'h00, 1'b0, 1'b0);
   endtask

   task automatic t_multi_col();
      logic [NC*NR-1:0] kv = '0;
      kv[0*NR + 0] = 1'b1;
      kv[1*NR + 0] = 1'b1;
      sweep_with(kv);
      chk(key_error == 1'b1, "R8 two columns error", 32'(key_error), 1);
      chk(key_valid == 1'b0, "R8 two columns valid", 32'(key_valid), 0);
      chk(key_code == (code_of(0, 0) | code_of(1, 0)), "R11 OR of codes",
          32'(key_code), 32'(code_of(0, 0) | code_of(1, 0)));
      sweep_with('0);
   endtask

   task automatic t_early_release();
      wait_done();
      press = '0;
      press[0*NR + 0] = 1'b1;
      repeat (SC - 2) @(negedge clk);
      press = '0;
      wait_done();
      expect_out("R3 early release ignored", 8'h00, 1'b0, 1'b0);
   endtask

   task automatic t_hold();
      bit ok = 1;
      logic [NC*NR-1:0] kv = '0;
      kv[0*NR + 2] = 1'b1;
      sweep_with(kv);
      repeat (SC) @(negedge clk);
      press = '0;
      while (!scan_done) begin
         if (!(key_valid && key_code == code_of(0, 2))) ok = 0;
         @(negedge clk);
      end
      chk(ok, "R7 held during sweep", 0, 1);
      expect_out("R7 held at sweep end", code_of(0, 2), 1'b1, 1'b0);
      wait_done();
      expect_out("R7 cleared after rescan", 8'h00, 1'b0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_scan_timing();
      t_none();
      t_single();
      t_multi_row();
      t_multi_col();
      t_early_release();
      t_hold();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule